// File: doc/BRIEF.md
# Smart Card Serial Port Line Status

This block holds the line status word of a smart card host serial port, together with the receive and transmit byte stores behind it. A receiver front end reports each finished character with its data and three error indications (line silent for a whole character, stop bit missing, parity wrong). The block stores those indications with the byte, so the status word always describes the byte that the host reads next. A transmitter back end takes bytes out of the transmit store one at a time.

The host reaches the block through a small register bus with a combinational read path. Reading the data register takes one received byte. Writing it queues one byte for transmission. Reading the status register clears the sticky error indications. One input chooses between single-register operation (capacity one in each direction) and store operation (capacity `DEPTH` in each direction). The block also raises an interrupt request when the transmit side runs dry and that interrupt is enabled, and it keeps two guard time registers that the host can read and write.

Top module: `sc_line_status`

## Requirements
- R1: After reset the status register (address 1) reads 0x20, the control register reads 0 and `irq` is 0.
- R2: Status bit 0 is 1 while at least one received byte is stored, and it returns to 0 once the host has read the last one.
- R3: Reading address 0 returns the oldest stored byte and removes it. Bytes come out in arrival order, and up to `DEPTH` bytes are held when `fifo_mode` is 1 (one byte when it is 0).
- R4: Status bits 4 (silent character), 3 (stop bit missing) and 2 (parity wrong) show the indications of the oldest stored byte. A status read clears the bits of that byte and clears bit 1 (overrun). The indications of later bytes remain and appear when those bytes become the oldest.
- R5: A byte that arrives while the store is full replaces the most recently stored byte and sets status bit 1. If the host removes a byte in the same cycle, the new byte is stored normally and bit 1 does not change.
- R6: When a status read coincides with an event that sets a flag (an overwrite, or a byte arriving at an empty store), the new flag value is kept.
- R7: Status bit 5 is 1 out of reset. A host write to address 0 clears it. It sets when `tx_load` removes the last queued byte. A write to a full transmit store (capacity one or `DEPTH`) is ignored.
- R8: `tx_avail` is 1 while a byte is queued, and `tx_byte` shows the oldest queued byte. Each `tx_load` removes one byte in write order.
- R9: `irq` equals control bit 0 (address 2, transmit-empty interrupt enable) AND status bit 5.
- R10: Guard time registers at addresses 3 and 4 are 8 bits wide, reset to 1, and can be read and written.
- R11: Reading address 0 with nothing stored returns 0 and changes nothing. `tx_load` with nothing queued changes nothing. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1: store operation, 0: single register; change only while both sides are empty |
| rx_done | input | 1 | One-cycle pulse: a character has been received |
| rx_data | input | 8 | Received data byte |
| rx_silent | input | 1 | Line was idle for a whole character time |
| rx_nostop | input | 1 | Stop bit missing |
| rx_parity | input | 1 | Parity wrong |
| tx_load | input | 1 | Transmitter takes the oldest queued byte |
| tx_avail | output | 1 | A byte is queued for transmission |
| tx_byte | output | 8 | Oldest queued transmit byte |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a flag-setting event: an overwrite of a full store, or a byte arriving at an empty store, where the read clears the slot that the new byte is written to. The bench drives each of these collisions on purpose, in single-register operation and against an empty store. It also fills the store past capacity and then removes a byte and pushes a new one in the same cycle, which exercises the boundary between room and overrun. A long pseudo-random phase then mixes all events against a queue-based reference model.

// File: rtl/sc_stat_pkg.sv
package sc_stat_pkg;

    localparam int DATA_W = 8;

    // status word bit positions (host software decodes these)
    localparam int ST_RDR = 0;
    localparam int ST_OVR = 1;
    localparam int ST_PAR = 2;
    localparam int ST_NSB = 3;
    localparam int ST_SIL = 4;
    localparam int ST_TBE = 5;

    typedef struct packed {
        logic silent;
        logic nostop;
        logic parity;
    } rx_err_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_err_t           err;
    } rx_entry_t;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_CTRL = 3'd2,
        A_GT0  = 3'd3,
        A_GT1  = 3'd4
    } reg_addr_e;

    function automatic logic [DATA_W-1:0] make_status(input logic tbe, input rx_err_t e,
                                                      input logic ovr, input logic rdr);
        logic [DATA_W-1:0] s;
        s         = '0;
        s[ST_TBE] = tbe;
        s[ST_SIL] = e.silent;
        s[ST_NSB] = e.nostop;
        s[ST_PAR] = e.parity;
        s[ST_OVR] = ovr;
        s[ST_RDR] = rdr;
        return s;
    endfunction

endpackage

// File: rtl/sc_rx_store.sv
module sc_rx_store
    import sc_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_mode,
    input  logic      push_req,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    input  logic      stat_rd,
    output logic      rdr,
    output logic      ovr,
    output rx_entry_t head
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    rx_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr, last_ptr;
    logic [CNT_W-1:0]  cnt, cap;
    logic              pop, room, push, ovw;

    assign cap      = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign pop      = pop_req && (cnt != '0);
    assign room     = (cnt < cap) || pop;
    assign push     = push_req && room;
    assign ovw      = push_req && !room;
    assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            ovr    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            // clear first: a byte written to the same slot below wins
            if (stat_rd && cnt != '0) mem[rd_ptr].err <= '0;
            if (push) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= nxt(wr_ptr);
            end else if (ovw) begin
                mem[last_ptr] <= push_entry;
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
            if (ovw)          ovr <= 1'b1;
            else if (stat_rd) ovr <= 1'b0;
        end
    end

    assign rdr  = (cnt != '0);
    assign head = rdr ? mem[rd_ptr] : '0;

    p_cnt_in_cap_r3: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
    p_ovr_on_overwrite_r5: assert property (@(posedge clk) disable iff (rst)
        ovw |=> ovr);
    p_room_no_ovr_r5: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop && !stat_rd) |=> (ovr == $past(ovr)));
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !ovw) |=> !ovr);
    p_new_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && push && cnt == '0) |=> (head.err == $past(push_entry.err)));
endmodule

// File: rtl/sc_tx_store.sv
module sc_tx_store
    import sc_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic              tbe,
    output logic              avail,
    output logic [DATA_W-1:0] out_byte
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt, cap;
    logic              push, pop;

    assign cap  = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign push = wr_req && (cnt < cap);
    assign pop  = load && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            tbe    <= 1'b1;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
            if (push)                         tbe <= 1'b0;
            else if (pop && cnt == CNT_W'(1)) tbe <= 1'b1;
        end
    end

    assign avail    = (cnt != '0);
    assign out_byte = mem[rd_ptr];

    p_tbe_is_empty_r7: assert property (@(posedge clk) disable iff (rst) tbe == (cnt == '0));
    p_tx_in_cap_r7: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
    p_write_clears_tbe_r7: assert property (@(posedge clk) disable iff (rst)
        push |=> !tbe);
endmodule

// File: rtl/sc_host_regs.sv
module sc_host_regs
    import sc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txie,
    output logic [DATA_W-1:0] gt0,
    output logic [DATA_W-1:0] gt1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            txie <= 1'b0;
            gt0  <= DATA_W'(1);
            gt1  <= DATA_W'(1);
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CTRL:  txie <= wdata[0];
                A_GT0:   gt0  <= wdata;
                A_GT1:   gt1  <= wdata;
                default: ;
            endcase
        end
    end

    p_gt0_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_GT0) |=> $stable(gt0));
    p_gt1_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_GT1) |=> $stable(gt1));
endmodule

// File: rtl/sc_line_status.sv
module sc_line_status
    import sc_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_silent,
    input  logic              rx_nostop,
    input  logic              rx_parity,
    input  logic              tx_load,
    output logic              tx_avail,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              rd_en, wr_en, rx_pop, st_rd, tx_wr;
    logic              rdr, ovr, tbe, txie;
    logic [DATA_W-1:0] gt0, gt1;
    rx_entry_t         in_entry, head;

    assign rd_en  = bus_sel && !bus_wr;
    assign wr_en  = bus_sel && bus_wr;
    assign rx_pop = rd_en && (bus_addr == A_DATA);
    assign st_rd  = rd_en && (bus_addr == A_STAT);
    assign tx_wr  = wr_en && (bus_addr == A_DATA);

    assign in_entry = '{data: rx_data, err: '{silent: rx_silent, nostop: rx_nostop, parity: rx_parity}};

    sc_rx_store #(.DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
        .push_req(rx_done), .push_entry(in_entry),
        .pop_req(rx_pop), .stat_rd(st_rd),
        .rdr(rdr), .ovr(ovr), .head(head)
    );

    sc_tx_store #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
        .wr_req(tx_wr), .wr_data(bus_wdata), .load(tx_load),
        .tbe(tbe), .avail(tx_avail), .out_byte(tx_byte)
    );

    sc_host_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .txie(txie), .gt0(gt0), .gt1(gt1)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_DATA:  bus_rdata = head.data;
            A_STAT:  bus_rdata = make_status(tbe, head.err, ovr, rdr);
            A_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, txie};
            A_GT0:   bus_rdata = gt0;
            A_GT1:   bus_rdata = gt1;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = txie && tbe;

    p_empty_read_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rdr && !rx_done) |=> !rdr);
    p_irq_needs_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_avail && !tx_load) |=> !irq);
endmodule

// File: tb/sim_sc_line_status.sv
`timescale 1ns/1ps
module sim_sc_line_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       rx_done = 1'b0, rx_silent = 1'b0, rx_nostop = 1'b0, rx_parity = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_avail, irq;
    logic [7:0] tx_byte, bus_rdata;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;

    always #10 clk = ~clk;

    sc_line_status #(.DEPTH(16)) u0 (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
        .rx_done(rx_done), .rx_data(rx_data), .rx_silent(rx_silent),
        .rx_nostop(rx_nostop), .rx_parity(rx_parity),
        .tx_load(tx_load), .tx_avail(tx_avail), .tx_byte(tx_byte),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model state
    logic [10:0] rxq[$];
    logic [7:0]  txq[$];
    logic        m_ovr = 1'b0, m_tbe = 1'b1, m_txie = 1'b0;
    logic [7:0]  m_gt0 = 8'd1, m_gt1 = 8'd1;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // one literal check per cycle: 0 rdata, 1 tx_byte, 2 irq, 3 tx_avail
    bit         lit_en = 0;
    int         lit_sel = 0;
    logic [7:0] lit_val = '0;
    string      lit_tag = "";

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIAL-free marker"); // never printed: replaced below
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        logic [2:0] e;
        e = (rxq.size() > 0) ? rxq[0][2:0] : 3'b0;
        case (a)
            3'd0: return (rxq.size() > 0) ? rxq[0][10:3] : 8'h00;
            3'd1: return {2'b00, m_tbe, e, m_ovr, rxq.size() > 0};
            3'd2: return {7'b0, m_txie};
            3'd3: return m_gt0;
            3'd4: return m_gt1;
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        string t;
        case (bus_addr)
            3'd0: t = "R3";
            3'd1: t = "R4";
            3'd2: t = "R9";
            3'd3, 3'd4: t = "R10";
            default: t = "R11";
        endcase
        chk(t, bus_rdata, exp_rdata(bus_addr));
        chk("R8 tx_avail", {7'b0, tx_avail}, {7'b0, txq.size() > 0});
        if (txq.size() > 0) chk("R8 tx_byte", tx_byte, txq[0]);
        chk("R9 irq", {7'b0, irq}, {7'b0, m_txie & m_tbe});
        if (lit_en) begin
            case (lit_sel)
                0: chk(lit_tag, bus_rdata, lit_val);
                1: chk(lit_tag, tx_byte, lit_val);
                2: chk(lit_tag, {7'b0, irq}, lit_val);
                default: chk(lit_tag, {7'b0, tx_avail}, lit_val);
            endcase
            lit_en = 0;
        end
    endtask

    task automatic model_step();
        int cap;
        bit rd, wr, pop, room, tpush, tpop;
        logic [10:0] ent;
        cap  = fifo_mode ? 16 : 1;
        rd   = bus_sel && !bus_wr;
        wr   = bus_sel && bus_wr;
        pop  = rd && bus_addr == 3'd0 && rxq.size() > 0;
        room = (rxq.size() < cap) || pop;
        ent  = {rx_data, rx_silent, rx_nostop, rx_parity};
        if (rd && bus_addr == 3'd1 && rxq.size() > 0) rxq[0][2:0] = 3'b0;
        if (rx_done && !room) m_ovr = 1'b1;
        else if (rd && bus_addr == 3'd1) m_ovr = 1'b0;
        if (pop) void'(rxq.pop_front());
        if (rx_done) begin
            if (room) rxq.push_back(ent);
            else rxq[rxq.size()-1] = ent;
        end
        tpush = wr && bus_addr == 3'd0 && txq.size() < cap;
        tpop  = tx_load && txq.size() > 0;
        if (tpush) m_tbe = 1'b0;
        else if (tpop && txq.size() == 1) m_tbe = 1'b1;
        if (tpop) void'(txq.pop_front());
        if (tpush) txq.push_back(bus_wdata);
        if (wr && bus_addr == 3'd2) m_txie = bus_wdata[0];
        if (wr && bus_addr == 3'd3) m_gt0 = bus_wdata;
        if (wr && bus_addr == 3'd4) m_gt1 = bus_wdata;
    endtask

    task automatic cyc(input logic s, input logic w, input logic [2:0] a, input logic [7:0] wd,
                       input logic rd_, input logic [7:0] rdd, input logic [2:0] er, input logic ld);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        rx_done = rd_; rx_data = rdd;
        {rx_silent, rx_nostop, rx_parity} = er;
        tx_load = ld;
        #1;
        compare_all();
        @(posedge clk);
        model_step();
    endtask

    task automatic idle();                                 cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic hrd(input logic [2:0] a);               cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
    task automatic hwr(input logic [2:0] a, input logic [7:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
    task automatic rxb(input logic [7:0] d, input logic [2:0] e); cyc(0, 0, 0, 0, 1, d, e, 0); endtask
    task automatic ld();                                   cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic set_lit(input int sel, input logic [7:0] v, input string tag);
        lit_en = 1; lit_sel = sel; lit_val = v; lit_tag = tag;
    endtask

    task automatic rd_lit(input logic [2:0] a, input logic [7:0] v, input string tag);
        set_lit(0, v, tag);
        hrd(a);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_lit(1, 8'h20, "R1 status");
        rd_lit(2, 8'h00, "R1 control");
        set_lit(2, 8'h00, "R1 irq");
        idle();
        rd_lit(3, 8'h01, "R10 gt0 reset");
        rd_lit(4, 8'h01, "R10 gt1 reset");

        // single register operation
        rxb(8'hA5, 3'b001);
        rd_lit(1, 8'h25, "R4 parity shown");
        rd_lit(1, 8'h21, "R4 cleared by read");
        rd_lit(0, 8'hA5, "R2 data");
        rd_lit(1, 8'h20, "R2 ready cleared");

        rxb(8'h11, 3'b000);
        rxb(8'h22, 3'b000);
        rd_lit(1, 8'h23, "R5 overrun single");
        rd_lit(0, 8'h22, "R5 newest kept");
        rd_lit(1, 8'h20, "R5 cleared");

        // R6: status read against overwrite
        rxb(8'h33, 3'b000);
        set_lit(0, 8'h21, "R6 pre");
        cyc(1, 0, 3'd1, 0, 1, 8'h44, 3'b010, 0);
        rd_lit(1, 8'h2B, "R6 overwrite wins");
        rd_lit(0, 8'h44, "R6 data");
        rd_lit(1, 8'h20, "R2 empty again");
        // R6: status read against byte arriving at empty store
        set_lit(0, 8'h20, "R6 empty pre");
        cyc(1, 0, 3'd1, 0, 1, 8'h55, 3'b100, 0);
        rd_lit(1, 8'h31, "R6 arrival wins");
        rd_lit(0, 8'h55, "R6 data2");

        // R11: empty data read, empty load
        rd_lit(0, 8'h00, "R11 empty read");
        rd_lit(1, 8'h20, "R11 no change");
        ld();
        set_lit(3, 8'h00, "R11 empty load");
        idle();
        rd_lit(5, 8'h00, "R11 unmapped");

        // transmit, single register
        hwr(0, 8'h5A);
        rd_lit(1, 8'h00, "R7 write clears empty");
        hwr(0, 8'h6B);
        set_lit(1, 8'h5A, "R7 extra write ignored");
        idle();
        ld();
        rd_lit(1, 8'h20, "R7 set after load");
        set_lit(3, 8'h00, "R8 none queued");
        idle();
        hwr(2, 8'h01);
        set_lit(2, 8'h01, "R9 irq on");
        idle();
        hwr(0, 8'h77);
        set_lit(2, 8'h00, "R9 irq off");
        idle();
        ld();
        set_lit(2, 8'h01, "R9 irq back");
        idle();
        hwr(2, 8'h00);

        // guard registers
        hwr(3, 8'h3C);
        hwr(4, 8'hC3);
        rd_lit(3, 8'h3C, "R10 gt0");
        rd_lit(4, 8'hC3, "R10 gt1");

        // store operation
        fifo_mode = 1'b1;
        for (int i = 0; i < 17; i++) rxb(8'(i * 7 + 1), 3'(i % 8));
        rd_lit(1, 8'h23, "R5 overrun full store");
        set_lit(0, 8'h01, "R3 oldest first");
        cyc(1, 0, 3'd0, 0, 1, 8'hEE, 3'b000, 0);
        rd_lit(1, 8'h25, "R5 pop makes room");
        for (int i = 0; i < 16; i++) begin
            hrd(1);
            hrd(0);
        end
        rd_lit(1, 8'h20, "R2 drained");

        for (int i = 0; i < 17; i++) hwr(0, 8'(8'h80 + i));
        set_lit(1, 8'h80, "R8 first queued");
        idle();
        for (int i = 0; i < 17; i++) begin
            ld();
            hrd(1);
        end
        rd_lit(1, 8'h20, "R7 empty after drain");

        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] a;
            for (int k = 0; k < 8; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = (lfsr[2:0] > 3'd4) ? 3'd1 : lfsr[2:0];
            cyc(lfsr[3], lfsr[4] & lfsr[5], a, lfsr[15:8], lfsr[6] & lfsr[7], lfsr[14:7],
                lfsr[11:9], lfsr[12] & lfsr[13]);
        end
        idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule